// File: doc/BRIEF.md
# Multicore Mailbox Doorbell Unit

This unit gives every processor core a small set of doorbell mailboxes that any other core can ring. With the default parameters there are four cores and four 32-bit mailboxes per core. A core rings a doorbell by writing a word to that mailbox's set window. Each 1-bit in the word is ORed into the mailbox. The owning core acknowledges one doorbell bit at a time by writing a one-hot word to the mailbox's clear window. That window also reads back the live contents, so no read-modify-write is ever needed, and a bit rung again after its clear stays visible.

Each core also has a per-core enable register. For every mailbox it holds one bit that routes the mailbox to a normal interrupt request and one bit that routes it to a fast interrupt request. The unit drives per-core request vectors. A mailbox requests while its contents are nonzero and its enable is set. A downstream pending-word block consumes these vectors. Register access goes through a simple word-wide port: one access per cycle, and read data is registered.

The decoder sorts each address into one of four windows: none, enable, set or clear. A `unique case` over that window kind selects the read source. There is no sequencing state, only the mailbox and enable registers.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every mailbox, every enable register, `bus_rdata`, `irq_req` and `fiq_req` are zero.
- R2: A write at byte offset 0x80 + 16n + 4m ORs the 1-bits of `bus_wdata` into mailbox m of core n. Its 0-bits leave the mailbox unchanged.
- R3: A write at byte offset 0xC0 + 16n + 4m clears every bit of mailbox m of core n where `bus_wdata` holds a 1.
- R4: A read at byte offset 0xC0 + 16n + 4m returns the mailbox contents on `bus_rdata` from the cycle after the read. The read leaves the mailbox unchanged. `bus_rdata` holds its value until the next read.
- R5: The enable register of core n sits at byte offset 0x50 + 4n. Bit m routes mailbox m to the normal request, and bit m+4 routes it to the fast request. Bits 31:8 are ignored on write and read as zero.
- R6: `irq_req[4n+m]` is high exactly while mailbox m of core n is nonzero and its normal enable bit is set. `fiq_req[4n+m]` follows the same rule with the fast enable bit. Both follow a register write from the next cycle on.
- R7: When a one-hot clear of a bit is followed by a set of that same bit, the bit reads back as 1 and keeps its request asserted.
- R8: Reads at the set offsets return zero.
- R9: Unaligned offsets and offsets outside the three windows read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 16 | Normal requests, bit 4n+m for mailbox m of core n |
| fiq_req | output | 16 | Fast requests, bit 4n+m for mailbox m of core n |

## Verification
Every mailbox is first loaded with a distinct nonzero pattern. Any slot mix-up in the set or clear decode therefore shows up as a wrong read-back or a wrong request bit. One-hot clears, multi-bit clears and a clear followed by a set of the same bit separate correct set-wins merging from plain overwrite or dropped sets. Writes to gap, unaligned and unmapped offsets expose decode that drops the alignment or range test. Enable patterns that set only the normal half or only the fast half show whether the two request vectors are routed from the right enable bits.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_CFG,
        WIN_SET,
        WIN_CLR
    } win_kind_t;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
    import doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NUM_BOX   = 4,
    parameter int unsigned CFG_BASE  = 'h50,
    parameter int unsigned SET_BASE  = 'h80,
    parameter int unsigned CLR_BASE  = 'hC0,
    localparam int unsigned SLOTS    = NUM_CORES * NUM_BOX,
    localparam int unsigned SLOT_W   = $clog2(SLOTS),
    localparam int unsigned CORE_W   = $clog2(NUM_CORES)
) (
    input  logic [ADDR_W-1:0] addr,
    output win_kind_t         kind,
    output logic [SLOT_W-1:0] slot,
    output logic [CORE_W-1:0] core
);
    localparam int unsigned CFG_WORD = CFG_BASE / 4;
    localparam int unsigned SET_WORD = SET_BASE / 4;
    localparam int unsigned CLR_WORD = CLR_BASE / 4;

    int unsigned word;

    always_comb begin
        word = 32'(addr[ADDR_W-1:2]);
        kind = WIN_NONE;
        slot = '0;
        core = '0;
        if (addr[1:0] == 2'b00) begin
            if (word >= CFG_WORD && word < CFG_WORD + NUM_CORES) begin
                kind = WIN_CFG;
                core = CORE_W'(word - CFG_WORD);
            end else if (word >= SET_WORD && word < SET_WORD + SLOTS) begin
                kind = WIN_SET;
                slot = SLOT_W'(word - SET_WORD);
            end else if (word >= CLR_WORD && word < CLR_WORD + SLOTS) begin
                kind = WIN_CLR;
                slot = SLOT_W'(word - CLR_WORD);
            end
        end
    end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] contents
);
    // A bit both set and cleared in one cycle ends up set.
    always_ff @(posedge clk) begin
        if (!rst_n) contents <= '0;
        else        contents <= (contents & ~clr_mask) | set_mask;
    end

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((contents & $past(set_mask)) == $past(set_mask)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_mask) != '0) |=> ((contents & $past(clr_mask & ~set_mask)) == '0));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(contents));
endmodule

// File: rtl/doorbell_gate.sv
module doorbell_gate #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_BOX = 4,
    localparam int unsigned CFG_W  = 2 * NUM_BOX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_BOX*DATA_W-1:0] boxes,
    output logic [CFG_W-1:0]          cfg_q,
    output logic [NUM_BOX-1:0]        irq,
    output logic [NUM_BOX-1:0]        fiq
);
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
    end

    always_comb begin
        for (int m = 0; m < NUM_BOX; m++) begin
            irq[m] = cfg_q[m]           & (|boxes[m*DATA_W +: DATA_W]);
            fiq[m] = cfg_q[m + NUM_BOX] & (|boxes[m*DATA_W +: DATA_W]);
        end
    end

    assert_cfg_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(wdata[CFG_W-1:0])));

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NUM_BOX   = 4,
    localparam int unsigned SLOTS    = NUM_CORES * NUM_BOX,
    localparam int unsigned SLOT_W   = $clog2(SLOTS),
    localparam int unsigned CORE_W   = $clog2(NUM_CORES),
    localparam int unsigned CFG_W    = 2 * NUM_BOX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SLOTS-1:0]  irq_req,
    output logic [SLOTS-1:0]  fiq_req
);
    win_kind_t         kind;
    logic [SLOT_W-1:0] slot;
    logic [CORE_W-1:0] core;
    logic              wr_go;
    logic              rd_go;

    logic [DATA_W-1:0]       box_q [SLOTS];
    logic [SLOTS*DATA_W-1:0] box_flat;
    logic [CFG_W-1:0]        cfg_q [NUM_CORES];

    assign wr_go = bus_en &  bus_we;
    assign rd_go = bus_en & ~bus_we;

    doorbell_decode #(
        .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .NUM_BOX(NUM_BOX)
    ) decode_i (
        .addr(bus_addr), .kind(kind), .slot(slot), .core(core)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_box
        logic [DATA_W-1:0] set_mask;
        logic [DATA_W-1:0] clr_mask;
        assign set_mask = (wr_go && kind == WIN_SET && slot == SLOT_W'(s)) ? bus_wdata : '0;
        assign clr_mask = (wr_go && kind == WIN_CLR && slot == SLOT_W'(s)) ? bus_wdata : '0;
        doorbell_mailbox #(.DATA_W(DATA_W)) box_i (
            .clk(clk), .rst_n(rst_n),
            .set_mask(set_mask), .clr_mask(clr_mask),
            .contents(box_q[s])
        );
        assign box_flat[s*DATA_W +: DATA_W] = box_q[s];
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic cfg_we;
        assign cfg_we = wr_go && kind == WIN_CFG && core == CORE_W'(c);
        doorbell_gate #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) gate_i (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(cfg_we), .wdata(bus_wdata),
            .boxes(box_flat[c*NUM_BOX*DATA_W +: NUM_BOX*DATA_W]),
            .cfg_q(cfg_q[c]),
            .irq(irq_req[c*NUM_BOX +: NUM_BOX]),
            .fiq(fiq_req[c*NUM_BOX +: NUM_BOX])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_go) begin
            unique case (kind)
                WIN_CFG: bus_rdata <= DATA_W'(cfg_q[core]);
                WIN_CLR: bus_rdata <= box_q[slot];
                WIN_SET: bus_rdata <= '0;
                default: bus_rdata <= '0;
            endcase
        end
    end

    assert_set_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && kind == WIN_SET) |=> (bus_rdata == '0));

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && kind == WIN_NONE) |=> (bus_rdata == '0));

    assert_rdata_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(bus_rdata));
endmodule

// File: tb/doorbell_unit_tb_top.sv
module doorbell_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_req;
    logic [15:0] fiq_req;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    doorbell_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .fiq_req(fiq_req)
    );

    // Behavioural reference model
    logic [31:0] m_box [16];
    logic [7:0]  m_cfg [4];
    logic [31:0] m_rd;
    string       m_tag = "R1";

    function automatic int win_of(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a >= 8'h50 && a < 8'h60) return 1;
        if (a >= 8'h80 && a < 8'hC0) return 2;
        if (a >= 8'hC0) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_box[i] = '0;
            for (int i = 0; i < 4; i++)  m_cfg[i] = '0;
            m_rd = '0;
            m_tag = "R1";
        end else if (bus_en) begin
            int w;
            w = win_of(bus_addr);
            if (!bus_we) begin
                case (w)
                    1: begin m_rd = {24'h0, m_cfg[(bus_addr - 8'h50) >> 2]}; m_tag = "R5"; end
                    2: begin m_rd = '0; m_tag = "R8"; end
                    3: begin m_rd = m_box[(bus_addr - 8'hC0) >> 2]; m_tag = "R4"; end
                    default: begin m_rd = '0; m_tag = "R9"; end
                endcase
            end else begin
                case (w)
                    1: m_cfg[(bus_addr - 8'h50) >> 2] = bus_wdata[7:0];
                    2: m_box[(bus_addr - 8'h80) >> 2] = m_box[(bus_addr - 8'h80) >> 2] | bus_wdata;
                    3: m_box[(bus_addr - 8'hC0) >> 2] = m_box[(bus_addr - 8'hC0) >> 2] & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_req(input bit fast);
        logic [15:0] v;
        for (int i = 0; i < 16; i++)
            v[i] = (m_box[i] != 0) && m_cfg[i/4][(i%4) + (fast ? 4 : 0)];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({m_tag, " rdata"}, bus_rdata, m_rd);
            check("R6 irq_req", {16'h0, irq_req}, {16'h0, model_req(1'b0)});
            check("R6 fiq_req", {16'h0, fiq_req}, {16'h0, model_req(1'b1)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] pat(input int s);
        return (32'hA5 << s) ^ 32'(s);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {16'h0, irq_req}, 32'h0);
        check("R1 fiq", {16'h0, fiq_req}, 32'h0);
        rd_expect(8'hD4, 32'h0, "R1 mailbox");
        rd_expect(8'h58, 32'h0, "R1 enable");

        // R2: distinct patterns into every mailbox
        for (int s = 0; s < 16; s++) wr(8'(8'h80 + 4*s), pat(s));
        for (int s = 0; s < 16; s++) rd_expect(8'(8'hC0 + 4*s), pat(s), "R2 set");
        wr(8'h8C, 32'hF000_0000);
        rd_expect(8'hCC, pat(3) | 32'hF000_0000, "R2 or-merge");
        rd_expect(8'hCC, pat(3) | 32'hF000_0000, "R4 read is non-destructive");

        // R8: set window reads zero
        rd_expect(8'h8C, 32'h0, "R8 set read");

        // R3: one-hot and multi-bit clears
        wr(8'hCC, 32'h1000_0000);
        rd_expect(8'hCC, pat(3) | 32'hE000_0000, "R3 one-hot clear");
        wr(8'hDC, 32'h0000_0F0F);
        rd_expect(8'hDC, pat(7) & ~32'h0000_0F0F, "R3 multi clear");
        wr(8'hC0, 32'hFFFF_FFFF);
        rd_expect(8'hC0, 32'h0, "R3 full clear");

        // R7: clear then set again of the same bit
        wr(8'hE4, 32'h0000_0020);
        wr(8'hA4, 32'h0000_0020);
        rd_expect(8'hE4, pat(9) | 32'h20, "R7 re-set visible");

        // R5/R6: enable registers and request routing
        wr(8'h54, 32'hFFFF_FF21);
        rd_expect(8'h54, 32'h0000_0021, "R5 enable width");
        check("R6 irq core1 box0", {31'h0, irq_req[4]}, 32'h1);
        check("R6 fiq core1 box1", {31'h0, fiq_req[5]}, 32'h1);
        check("R6 irq core1 box1 off", {31'h0, irq_req[5]}, 32'h0);
        wr(8'hD0, 32'hFFFF_FFFF);
        check("R6 irq drops on empty", {31'h0, irq_req[4]}, 32'h0);
        wr(8'h90, 32'h0000_0001);
        check("R6 irq returns on set", {31'h0, irq_req[4]}, 32'h1);
        wr(8'hE4, 32'h0000_0020);
        wr(8'h5C, 32'h0000_00F0);
        check("R6 fast only core3", {16'h0, fiq_req}, 32'h0000_F020);
        check("R6 normal core3 off", {16'h0, irq_req & 16'hF000}, 32'h0);

        // R9: writes to holes and unaligned offsets change nothing
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h81, 32'hFFFF_FFFF);
        wr(8'hC1, 32'hFFFF_FFFF);
        wr(8'h52, 32'hFFFF_FFFF);
        rd_expect(8'hC0, 32'h0, "R9 unaligned set ignored");
        rd_expect(8'hC4, pat(1), "R9 unaligned clear ignored");
        rd_expect(8'h50, 32'h0, "R9 unaligned enable ignored");
        rd_expect(8'h60, 32'h0, "R9 hole read");
        rd_expect(8'h81, 32'h0, "R9 unaligned read");
        for (int c = 0; c < 4; c++) wr(8'(8'h50 + 4*c), 32'hFF);
        check("R6 all enabled irq", {16'h0, irq_req}, {16'h0, model_req(1'b0)});

        done = 1'b1;
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule